// File: doc/BRIEF.md
# DDR SDRAM Bring-up and Refresh Sequencer

This block sits on the controller side of a DDR SDRAM interface and owns the command bus from reset until the memory is ready for traffic. It holds the clock enable low for a power-up wait and then raises it. It then plays a fixed start-up sequence:

1. precharge all banks,
2. write the extended register with the DLL turned on,
3. write the mode register with the DLL-reset bit set,
4. precharge all banks again,
5. issue two auto refreshes,
6. write the mode register a final time without the DLL-reset bit.

Every gap between commands is a parameter counted in clock cycles.

After start-up the block tells the user path that ordinary commands are allowed. It raises a separate flag once the DLL lock wait has run out, and only then may reads be issued. From that point it owes the device one auto refresh per refresh interval. The owed refreshes are counted. A refresh is issued only when the user path grants the bus, which promises that every bank is precharged. While the owed count sits at its ceiling, an urgent flag tells the user path to close its banks and grant.

Top module: `ddr_bringup_seq`

## Requirements
- R1: While reset is held, clock enable is low, the command is deselect (chip select, row strobe, column strobe and write enable all high), and `init_done`, `read_ok` and `ref_req` are low while `bus_busy` is high.
- R2: After reset, clock enable stays low with deselect for T_PWR clock edges. It then goes high and stays high. The first command follows one cycle after clock enable rises.
- R3: The start-up commands come in this order: precharge-all, extended register write, mode write with DLL reset, precharge-all, refresh, refresh, final mode write.
- R4: Commands are encoded as {cs_n, ras_n, cas_n, we_n}: no-op 0111, precharge 0010 with address bit 10 high (all banks), auto refresh 0001, register write 0000.
- R5: The extended register write drives bank address 01 and an all-zero address, so bit 0 low turns the DLL on.
- R6: Both mode writes drive bank address 00, with these fields:
  - bits 2:0 give the burst length: 001 for 2, 010 for 4, 011 for 8;
  - bit 3 gives the burst type: 1 for interleaved;
  - bits 6:4 give the CAS latency: 010 for 2, 110 for 2.5, 011 for 3;
  - bit 7 is 0;
  - bit 8 is 1 on the first write and 0 on the final one;
  - all higher bits are 0.
- R7: The next command follows exactly T_RP cycles after a precharge, T_MRD cycles (at least 2) after a register write, and T_RFC cycles after a refresh.
- R8: `init_done` rises exactly T_MRD cycles after the final mode write.
- R9: `read_ok` is never high before `init_done`. It rises T_DLL cycles after the DLL-reset mode write, or together with `init_done` if that comes later.
- R10: Once `init_done` is high, one refresh is owed every T_REFI cycles, counted from the cycle `init_done` rose. `ref_req` is high while any refresh is owed.
- R11: A refresh is issued in the cycle after `ref_gnt` is sampled high while a refresh is owed and no refresh window is open. Each refresh clears one owed refresh. `bus_busy` is high from the refresh cycle up to the cycle before the next command may be issued. No other command is issued after start-up.
- R12: `ref_urgent` is high while MAX_DEBT refreshes are owed. Interval ends that pass while the count is at that ceiling are dropped, so at most MAX_DEBT refreshes follow a late grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | User path grants the bus; all banks are precharged |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Start-up complete; non-read commands allowed |
| read_ok | output | 1 | DLL lock wait over; reads allowed |
| ref_req | output | 1 | At least one refresh owed |
| ref_urgent | output | 1 | Owed count at its ceiling |
| bus_busy | output | 1 | Sequencer owns the command bus |

## Verification
The bench builds the block with the following parameter values:

| Parameter | Value |
|-----------|-------|
| T_PWR | 10 |
| T_RP | 3 |
| T_MRD | 2 |
| T_RFC | 9 |
| T_DLL | 200 |
| T_REFI | 60 |
| MAX_DEBT | 3 |
| burst length | 4, sequential |
| CAS latency | 2.5 |

With these values the whole start-up finishes well inside the DLL wait, so `read_ok` trails `init_done` and the two flags can be told apart. A ceiling of 3 and a 60-cycle interval let the owed count fill and then overflow within a few hundred cycles. Two grants are placed one cycle after an interval ends, so the back-to-back refresh bursts finish before the next interval ends and the exact number of refreshes issued is known.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_DESL = 4'b1111,
      CMD_NOP  = 4'b0111,
      CMD_PRE  = 4'b0010,
      CMD_REF  = 4'b0001,
      CMD_MRW  = 4'b0000
   } cmd_e;

   typedef enum logic [3:0] {
      ST_PWR, ST_PALL1, ST_EXT, ST_MRW_RST, ST_PALL2,
      ST_REF1, ST_REF2, ST_MRW_FIN, ST_RUN
   } step_e;

   function automatic logic [2:0] burst_code(int len);
      case (len)
         2:       return 3'b001;
         4:       return 3'b010;
         8:       return 3'b011;
         default: return 3'b000;
      endcase
   endfunction

   // latency given in half cycles: 4 = 2, 5 = 2.5, 6 = 3
   function automatic logic [2:0] lat_code(int half_cycles);
      case (half_cycles)
         4:       return 3'b010;
         5:       return 3'b110;
         6:       return 3'b011;
         default: return 3'b000;
      endcase
   endfunction

endpackage

// File: rtl/dbs_timer.sv
module dbs_timer #(
   parameter int          W    = 8,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= INIT;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/dbs_dll_wait.sv
module dbs_dll_wait #(
   parameter int T_DLL = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic locked
);
   generate
      if (T_DLL == 0) begin : g_nowait
         logic armed;
         always_ff @(posedge clk) begin
            if (!rst_n)     armed <= 1'b0;
            else if (start) armed <= 1'b1;
         end
         assign locked = armed;
      end else begin : g_count
         localparam int LW = $clog2(T_DLL + 1);
         logic [LW-1:0] cnt;
         logic          armed;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt   <= '0;
               armed <= 1'b0;
            end else if (start) begin
               cnt   <= LW'(T_DLL);
               armed <= 1'b1;
            end else if (cnt != '0) begin
               cnt   <= cnt - 1'b1;
            end
         end
         assign locked = armed && (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/dbs_refresh_debt.sv
module dbs_refresh_debt #(
   parameter int T_REFI   = 1560,
   parameter int MAX_DEBT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic take,
   output logic pending,
   output logic full
);
   localparam int IW = $clog2(T_REFI);
   localparam int DW = $clog2(MAX_DEBT + 1);

   logic [IW-1:0] ivl;
   logic [DW-1:0] debt;
   logic          tick;
   logic          inc;

   assign tick = run && (ivl == IW'(T_REFI - 1));
   assign full = (debt == DW'(MAX_DEBT));
   assign inc  = tick && (!full || take);
   assign pending = (debt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)      ivl <= '0;
      else if (tick)   ivl <= '0;
      else if (run)    ivl <= ivl + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               debt <= '0;
      else if (inc && !take)    debt <= debt + 1'b1;
      else if (take && !inc)    debt <= debt - 1'b1;
   end
endmodule

// File: rtl/ddr_bringup_seq.sv
module ddr_bringup_seq
   import dbs_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int T_PWR       = 40000,
   parameter int T_RP        = 3,
   parameter int T_MRD       = 2,
   parameter int T_RFC       = 15,
   parameter int T_DLL       = 200,
   parameter int T_REFI      = 1560,
   parameter int MAX_DEBT    = 8,
   parameter int BURST_LEN   = 4,
   parameter bit BURST_INTLV = 1'b0,
   parameter int CAS_X2      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_gnt,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done,
   output logic              read_ok,
   output logic              ref_req,
   output logic              ref_urgent,
   output logic              bus_busy
);
   localparam int GMAX_A = (T_PWR - 1 > T_RP) ? T_PWR - 1 : T_RP;
   localparam int GMAX_B = (T_MRD > T_RFC) ? T_MRD : T_RFC;
   localparam int GMAX   = (GMAX_A > GMAX_B) ? GMAX_A : GMAX_B;
   localparam int TW     = $clog2(GMAX + 1);

   localparam logic [8:0] MODE_BASE = {1'b0, 1'b0, lat_code(CAS_X2), BURST_INTLV, burst_code(BURST_LEN)};
   localparam logic [ADDR_W-1:0] MODE_RUN = ADDR_W'(MODE_BASE);
   localparam logic [ADDR_W-1:0] MODE_RST = MODE_RUN | (ADDR_W'(1) << 8);

   generate
      if (ADDR_W < 11)               begin : g_bad_aw  $error("ADDR_W must be at least 11"); end
      if (T_MRD < 2)                 begin : g_bad_mrd $error("T_MRD must be at least 2"); end
      if (T_PWR < 1 || T_RP < 1 || T_RFC < 1) begin : g_bad_gap $error("gaps must be at least 1"); end
      if (T_REFI < 2)                begin : g_bad_ri  $error("T_REFI must be at least 2"); end
      if (MAX_DEBT < 1)              begin : g_bad_md  $error("MAX_DEBT must be at least 1"); end
      if (burst_code(BURST_LEN) == 3'b000) begin : g_bad_bl $error("BURST_LEN must be 2, 4 or 8"); end
      if (lat_code(CAS_X2) == 3'b000)      begin : g_bad_cl $error("CAS_X2 must be 4, 5 or 6"); end
   endgenerate

   step_e             step;
   cmd_e              cmd_q;
   logic              cke_q;
   logic [1:0]        ba_q;
   logic [ADDR_W-1:0] addr_q;
   logic              done_r;

   logic              tmr_zero;
   logic              tmr_load;
   logic [TW-1:0]     tmr_val;
   logic              adv;
   logic              issue_ref;
   logic              dll_locked;
   logic              debt_pending;
   logic              debt_full;

   assign adv       = tmr_zero && (step != ST_RUN);
   assign issue_ref = (step == ST_RUN) && tmr_zero && done_r && debt_pending && ref_gnt;
   assign tmr_load  = adv || issue_ref;

   always_comb begin
      case (step)
         ST_PALL1, ST_PALL2:                tmr_val = TW'(T_RP - 1);
         ST_EXT, ST_MRW_RST, ST_MRW_FIN:    tmr_val = TW'(T_MRD - 1);
         ST_REF1, ST_REF2, ST_RUN:          tmr_val = TW'(T_RFC - 1);
         default:                           tmr_val = '0;
      endcase
   end

   dbs_timer #(.W(TW), .INIT(TW'(T_PWR - 1))) u_gap (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
   );

   dbs_dll_wait #(.T_DLL(T_DLL)) u_dll (
      .clk(clk), .rst_n(rst_n), .start(adv && (step == ST_MRW_RST)), .locked(dll_locked)
   );

   dbs_refresh_debt #(.T_REFI(T_REFI), .MAX_DEBT(MAX_DEBT)) u_debt (
      .clk(clk), .rst_n(rst_n), .run(done_r), .take(issue_ref),
      .pending(debt_pending), .full(debt_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step   <= ST_PWR;
         cmd_q  <= CMD_DESL;
         cke_q  <= 1'b0;
         ba_q   <= '0;
         addr_q <= '0;
         done_r <= 1'b0;
      end else begin
         cmd_q  <= cke_q ? CMD_NOP : CMD_DESL;
         ba_q   <= '0;
         addr_q <= '0;
         if (adv) begin
            case (step)
               ST_PWR: begin
                  cke_q <= 1'b1;
                  cmd_q <= CMD_NOP;
                  step  <= ST_PALL1;
               end
               ST_PALL1: begin
                  cmd_q      <= CMD_PRE;
                  addr_q[10] <= 1'b1;
                  step       <= ST_EXT;
               end
               ST_EXT: begin
                  cmd_q <= CMD_MRW;
                  ba_q  <= 2'b01;
                  step  <= ST_MRW_RST;
               end
               ST_MRW_RST: begin
                  cmd_q  <= CMD_MRW;
                  addr_q <= MODE_RST;
                  step   <= ST_PALL2;
               end
               ST_PALL2: begin
                  cmd_q      <= CMD_PRE;
                  addr_q[10] <= 1'b1;
                  step       <= ST_REF1;
               end
               ST_REF1: begin
                  cmd_q <= CMD_REF;
                  step  <= ST_REF2;
               end
               ST_REF2: begin
                  cmd_q <= CMD_REF;
                  step  <= ST_MRW_FIN;
               end
               ST_MRW_FIN: begin
                  cmd_q  <= CMD_MRW;
                  addr_q <= MODE_RUN;
                  step   <= ST_RUN;
               end
               default: step <= ST_RUN;
            endcase
         end
         if ((step == ST_RUN) && tmr_zero) done_r <= 1'b1;
         if (issue_ref) cmd_q <= CMD_REF;
      end
   end

   assign cke        = cke_q;
   assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
   assign ba         = ba_q;
   assign addr       = addr_q;
   assign init_done  = done_r;
   assign read_ok    = done_r && dll_locked;
   assign ref_req    = debt_pending;
   assign ref_urgent = debt_full;
   assign bus_busy   = !done_r || !tmr_zero || (cmd_q == CMD_REF);
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_gnt,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [1:0]        ba,
   input logic [ADDR_W-1:0] addr,
   input logic              init_done,
   input logic              read_ok,
   input logic              ref_req,
   input logic              ref_urgent,
   input logic              bus_busy
);
   logic [3:0] cmd;
   logic       is_mrw, is_ref, is_pre;
   assign cmd    = {cs_n, ras_n, cas_n, we_n};
   assign is_mrw = (cmd == 4'b0000);
   assign is_ref = (cmd == 4'b0001);
   assign is_pre = (cmd == 4'b0010);

   assert_deselect_when_asleep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> cs_n);

   assert_cke_stays_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   assert_cke_before_regwrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrw || is_ref) |-> cke);

   assert_precharge_all_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> addr[10]);

   assert_ext_write_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrw && ba == 2'b01) |-> (addr == '0));

   assert_regwrite_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrw |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

   assert_reads_after_init_R9: assert property (@(posedge clk) disable iff (!rst_n)
      read_ok |-> init_done);

   assert_refresh_granted_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref && init_done) |-> $past(ref_gnt));

   assert_busy_on_refresh_R11: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> bus_busy);

   assert_urgent_implies_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> ref_req);
endmodule

bind ddr_bringup_seq dbs_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .cke(cke),
   .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
   .ba(ba), .addr(addr), .init_done(init_done), .read_ok(read_ok),
   .ref_req(ref_req), .ref_urgent(ref_urgent), .bus_busy(bus_busy)
);

// File: tb/ddr_bringup_seq_tb_top.sv
module ddr_bringup_seq_tb_top;
   localparam int AW     = 13;
   localparam int P_PWR  = 10;
   localparam int P_RP   = 3;
   localparam int P_MRD  = 2;
   localparam int P_RFC  = 9;
   localparam int P_DLL  = 200;
   localparam int P_REFI = 60;
   localparam int P_MAXD = 3;
   // burst 4 sequential -> 010, type 0, latency 2.5 -> 110
   localparam int MODE_RUN = (3'b110 << 4) | (0 << 3) | 3'b010;
   localparam int MODE_RST = MODE_RUN | (1 << 8);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_gnt = 1'b0;
   logic          cke, cs_n, ras_n, cas_n, we_n;
   logic [1:0]    ba;
   logic [AW-1:0] addr;
   logic          init_done, read_ok, ref_req, ref_urgent, bus_busy;

   always #4 clk = ~clk;

   ddr_bringup_seq #(
      .ADDR_W(AW), .T_PWR(P_PWR), .T_RP(P_RP), .T_MRD(P_MRD), .T_RFC(P_RFC),
      .T_DLL(P_DLL), .T_REFI(P_REFI), .MAX_DEBT(P_MAXD),
      .BURST_LEN(4), .BURST_INTLV(1'b0), .CAS_X2(5)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .cke(cke),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .init_done(init_done), .read_ok(read_ok),
      .ref_req(ref_req), .ref_urgent(ref_urgent), .bus_busy(bus_busy)
   );

   typedef struct {
      int    cmd;
      int    bank;
      int    adr;
      int    gap;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   int   cyc     = 0;
   int   last_cmd = -1;
   int   cke_rise = -1, init_rise = -1, read_rise = -1;
   int   req_rise = -1, urg_rise = -1, dll_cyc = -1, fin_mrw = -1;
   bit   finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push_exp(input int c, input int b, input int a, input int g, input string t);
      exp_t e;
      e.cmd = c; e.bank = b; e.adr = a; e.gap = g; e.tag = t;
      exp_q.push_back(e);
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) begin
         @(negedge clk);
         #1;
      end
   endtask

   // monitor: pops expected commands as they appear
   always @(negedge clk) begin
      if (rst_n) begin
         int c;
         cyc++;
         c = {cs_n, ras_n, cas_n, we_n};
         if (cke && cke_rise < 0) begin
            cke_rise = cyc;
            last_cmd = cyc;
         end
         if (init_done && init_rise < 0) init_rise = cyc;
         if (read_ok && read_rise < 0)   read_rise = cyc;
         if (ref_req && req_rise < 0)    req_rise = cyc;
         if (ref_urgent && urg_rise < 0) urg_rise = cyc;
         if (c != 4'b0111 && c != 4'b1111) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R11", "unexpected command", c, 4'b0111);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(c == e.cmd, e.tag, "command code", c, e.cmd);
               chk(int'(ba) == e.bank, e.tag, "bank address", int'(ba), e.bank);
               chk(int'(addr) == e.adr, e.tag, "address", int'(addr), e.adr);
               if (e.gap != 0)
                  chk(cyc - last_cmd == e.gap, "R7", "command spacing", cyc - last_cmd, e.gap);
            end
            if (c == 4'b0000 && addr[8]) dll_cyc = cyc;
            if (c == 4'b0000 && ba == 2'b00) fin_mrw = cyc;
            last_cmd = cyc;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(cke == 1'b0, "R1", "cke in reset", cke, 0);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1", "command in reset",
          {cs_n, ras_n, cas_n, we_n}, 4'b1111);
      chk(init_done == 1'b0, "R1", "init_done in reset", init_done, 0);
      chk(read_ok == 1'b0, "R1", "read_ok in reset", read_ok, 0);
      chk(ref_req == 1'b0, "R1", "ref_req in reset", ref_req, 0);
      chk(bus_busy == 1'b1, "R1", "bus_busy in reset", bus_busy, 1);

      // R3 order, R4 codes, R5 extended register, R6 mode fields, R2 first gap
      push_exp(4'b0010, 0, 1 << 10, 1, "R2_R3_R4");
      push_exp(4'b0000, 1, 0, P_RP, "R3_R5");
      push_exp(4'b0000, 0, MODE_RST, P_MRD, "R3_R6");
      push_exp(4'b0010, 0, 1 << 10, P_MRD, "R3_R4");
      push_exp(4'b0001, 0, 0, P_RP, "R3_R4");
      push_exp(4'b0001, 0, 0, P_RFC, "R3_R4");
      push_exp(4'b0000, 0, MODE_RUN, P_RFC, "R3_R6");

      @(negedge clk);
      #1 rst_n = 1'b1;

      while (init_rise < 0) begin
         @(negedge clk);
         #1;
      end
      chk(cke_rise == P_PWR, "R2", "cke rise cycle", cke_rise, P_PWR);
      chk(init_rise - fin_mrw == P_MRD, "R8", "init_done after final write", init_rise - fin_mrw, P_MRD);
      chk(read_ok == 1'b0, "R9", "read_ok at init_done", read_ok, 0);
      chk(exp_q.size() == 0, "R3", "start-up commands left", exp_q.size(), 0);

      wait_cyc(dll_cyc + P_DLL + 2);
      chk(read_rise - dll_cyc == P_DLL, "R9", "DLL wait length", read_rise - dll_cyc, P_DLL);

      // grant withheld: debt fills
      wait_cyc(init_rise + P_MAXD * P_REFI);
      chk(req_rise - init_rise == P_REFI, "R10", "first refresh owed", req_rise - init_rise, P_REFI);
      chk(urg_rise - init_rise == P_MAXD * P_REFI, "R12", "urgent rise", urg_rise - init_rise, P_MAXD * P_REFI);

      // R11 grant: exactly MAX_DEBT refreshes, spaced by T_RFC
      push_exp(4'b0001, 0, 0, 0, "R11");
      push_exp(4'b0001, 0, 0, P_RFC, "R11");
      push_exp(4'b0001, 0, 0, P_RFC, "R11");
      wait_cyc(init_rise + P_MAXD * P_REFI + 1);
      ref_gnt = 1'b1;
      while (exp_q.size() != 0) begin
         @(negedge clk);
         #1;
      end
      begin
         int r3;
         r3 = last_cmd;
         chk(ref_req == 1'b0, "R11", "owed after grant", ref_req, 0);
         ref_gnt = 1'b0;
         wait_cyc(r3 + P_RFC - 2);
         chk(bus_busy == 1'b1, "R11", "busy in refresh window", bus_busy, 1);
         wait_cyc(r3 + P_RFC - 1);
         chk(bus_busy == 1'b0, "R11", "busy after window", bus_busy, 0);
      end

      // R12 overflow: six intervals pass, only MAX_DEBT owed
      wait_cyc(init_rise + 9 * P_REFI);
      chk(ref_urgent == 1'b1, "R12", "urgent while saturated", ref_urgent, 1);
      push_exp(4'b0001, 0, 0, 0, "R12");
      push_exp(4'b0001, 0, 0, P_RFC, "R12");
      push_exp(4'b0001, 0, 0, P_RFC, "R12");
      wait_cyc(init_rise + 9 * P_REFI + 1);
      ref_gnt = 1'b1;
      while (exp_q.size() != 0) begin
         @(negedge clk);
         #1;
      end
      chk(ref_req == 1'b0, "R12", "owed after saturated grant", ref_req, 0);
      wait_cyc(init_rise + 10 * P_REFI - 1);
      chk(ref_req == 1'b0, "R12", "owed before next interval", ref_req, 0);
      wait_cyc(init_rise + 10 * P_REFI);
      chk(ref_req == 1'b1, "R10", "owed at next interval", ref_req, 1);
      ref_gnt = 1'b0;
      wait_cyc(init_rise + 10 * P_REFI + 2);

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule